// File: doc/BRIEF.md
# In-Place Even/Odd Block Reorder Engine

This block holds a small array of data blocks in an internal single-port memory and puts them back into natural order after they were loaded split by parity: every even-indexed block first, then every odd-indexed block. A block is modelled as one wide word. The host loads the memory through a write port, pulses a start input, waits for a one-cycle completion pulse and then reads the reordered words back through a read port.

The reorder makes no comparisons and uses no second buffer. The needed permutation is fixed. The word that belongs in slot q sits at the slot whose index is q rotated right by one bit. For the default of 16 blocks, index 1 (0001) maps to 8 (1000). The engine walks each cycle of this permutation with a single spare block register. It saves the first word it will overwrite and shifts every other word of the cycle one step along. It then drops the saved word into the cycle leader. Leaders are found by scanning the indices and skipping any slot already moved, using one visited bit per slot. This works for any power-of-two block count. For 16 blocks the cycles are {1,2,4,8}, {3,6,12,9}, {5,10} and {7,14,13,11}. The memory does one access per clock, so every move is a read cycle followed by a write cycle.

Top module: `blk_reorder_top`

## Requirements
- R1: While reset is held and right after it, `busy` and `done` are both 0.
- R2: After a run, slot q holds the word that was in slot rotr(q) when start was accepted, where rotr rotates the index right by one bit (bit 0 moves to the top bit). Two back-to-back runs therefore give slot q the word first loaded at rotr(rotr(q)).
- R3: Slots 0 and N-1 are fixed points and are never written during a run, so their contents are unchanged.
- R4: During one run every slot is written at most once.
- R5: `done` is high for exactly one clock when the last move is written. `busy` is low in that cycle and stays low afterwards until the next start.
- R6: A start pulse seen while `busy` is high is ignored. The run continues to a single `done` pulse, and the result is that of one run.
- R7: A load-port write (`ld_en` high) while `busy` is high is ignored and cannot corrupt the result.
- R8: While idle, `rd_data` shows the word at `rd_addr` one clock after the address is presented. While idle, a write with `ld_en` high stores `ld_data` at `ld_addr`.
- R9: `busy` goes high in the cycle after a start is accepted while idle, and it only rises after a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reorder run (accepted only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse at completion |
| ld_en | input | 1 | Load-port write enable (idle only) |
| ld_addr | input | IDX_W | Load-port slot index |
| ld_data | input | BLK_W | Load-port block word |
| rd_addr | input | IDX_W | Read-port slot index |
| rd_data | output | BLK_W | Word at the slot addressed on the previous clock |

## Verification
The assertions assume that the host never expects the read port to be valid while `busy` is high. They also assume that start and load writes seen during a run are dropped rather than queued. The single-write and fixed-point checks rely on the visited bits being cleared only when a start is accepted from idle. The stimulus stays within these limits: it loads and reads only while idle, waits for `done` before any read-back, and only asserts start or write strobes mid-run in the deliberate cases that test they are ignored.

// File: rtl/reorder_pkg.sv
package reorder_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_MV_RD,
    ST_MV_WR,
    ST_TMP_WR,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/idx_rotr.sv
// Rotates an index right by one bit: bit 0 wraps to the top.
module idx_rotr #(
  parameter int IW = 4
) (
  input  logic [IW-1:0] idx_in,
  output logic [IW-1:0] idx_out
);
  for (genvar i = 0; i < IW; i++) begin : g_bit
    assign idx_out[i] = idx_in[(i + 1) % IW];
  end
endmodule

// File: rtl/blk_ram.sv
// Single-port memory, one access per clock, registered read (read-first).
module blk_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/reorder_seq.sv
// Cycle-following sequencer: one spare block register, visited bit per slot.
module reorder_seq
  import reorder_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int BLK_W   = 32,
  localparam int IW = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [IW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [BLK_W-1:0] mem_wdata,
  input  logic [BLK_W-1:0] mem_rdata
);
  localparam logic [IW-1:0] LAST = IW'(NUM_BLK - 1);

  seq_state_t         state;
  logic [IW-1:0]      scan_idx;
  logic [IW-1:0]      leader;
  logic [IW-1:0]      cur;
  logic               first_mv;
  logic [BLK_W-1:0]   spare;
  logic [NUM_BLK-1:0] visited;

  logic [IW-1:0] scan_rot;
  logic [IW-1:0] cur_rot;
  logic          scan_skip;

  idx_rotr #(.IW(IW)) u_rot_scan (.idx_in(scan_idx), .idx_out(scan_rot));
  idx_rotr #(.IW(IW)) u_rot_cur  (.idx_in(cur),      .idx_out(cur_rot));

  assign scan_skip = visited[scan_idx] || (scan_rot == scan_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      scan_idx <= '0;
      leader   <= '0;
      cur      <= '0;
      first_mv <= 1'b0;
      spare    <= '0;
      visited  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_SCAN;
            scan_idx <= '0;
            visited  <= '0;
          end
        end
        ST_SCAN: begin
          if (scan_skip) begin
            visited[scan_idx] <= 1'b1;
            if (scan_idx == LAST) state <= ST_FIN;
            else                  scan_idx <= scan_idx + 1'b1;
          end else begin
            leader   <= scan_idx;
            cur      <= scan_rot;
            first_mv <= 1'b1;
            state    <= ST_MV_RD;
          end
        end
        ST_MV_RD: begin
          if (first_mv) spare <= mem_rdata;
          first_mv <= 1'b0;
          state    <= ST_MV_WR;
        end
        ST_MV_WR: begin
          visited[cur] <= 1'b1;
          cur          <= cur_rot;
          state        <= (cur_rot == leader) ? ST_TMP_WR : ST_MV_RD;
        end
        ST_TMP_WR: begin
          visited[leader] <= 1'b1;
          if (scan_idx == LAST) state <= ST_FIN;
          else begin
            scan_idx <= scan_idx + 1'b1;
            state    <= ST_SCAN;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_wdata = mem_rdata;
    unique case (state)
      ST_SCAN:   mem_addr = scan_rot;
      ST_MV_RD:  mem_addr = cur_rot;
      ST_MV_WR:  begin mem_addr = cur;    mem_we = 1'b1; end
      ST_TMP_WR: begin mem_addr = leader; mem_we = 1'b1; mem_wdata = spare; end
      default:   mem_addr = '0;
    endcase
  end

  assign busy = (state == ST_SCAN) || (state == ST_MV_RD) ||
                (state == ST_MV_WR) || (state == ST_TMP_WR);
  assign done = (state == ST_FIN);

  // Fixed points are never written.
  assert_fixed_untouched_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr != '0 && mem_addr != LAST));

  // No slot written twice within one run.
  assert_single_write_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !visited[mem_addr]);

  // Completion pulse lasts one clock and is not overlapped by busy.
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // A start mid-run never restarts the scan.
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  // Busy only rises as a result of a start.
  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/blk_reorder_top.sv
module blk_reorder_top #(
  parameter int NUM_BLK = 16,
  parameter int BLK_W   = 32,
  localparam int IDX_W = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_addr,
  input  logic [BLK_W-1:0] ld_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [BLK_W-1:0] rd_data
);
  logic [IDX_W-1:0] seq_addr;
  logic             seq_we;
  logic [BLK_W-1:0] seq_wdata;
  logic [IDX_W-1:0] ram_addr;
  logic             ram_we;
  logic [BLK_W-1:0] ram_wdata;
  logic [BLK_W-1:0] ram_rdata;

  reorder_seq #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_addr  (seq_addr),
    .mem_we    (seq_we),
    .mem_wdata (seq_wdata),
    .mem_rdata (ram_rdata)
  );

  // The sequencer owns the single port for the whole run.
  always_comb begin
    if (busy) begin
      ram_addr  = seq_addr;
      ram_we    = seq_we;
      ram_wdata = seq_wdata;
    end else begin
      ram_addr  = ld_en ? ld_addr : rd_addr;
      ram_we    = ld_en;
      ram_wdata = ld_data;
    end
  end

  blk_ram #(.DEPTH(NUM_BLK), .WIDTH(BLK_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign rd_data = ram_rdata;

  // Load-port writes never reach memory during a run.
  assert_load_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && ld_en && !seq_we) |-> !ram_we);
endmodule

// File: tb/sim_blk_reorder_top.sv
`timescale 1ns/1ps
module sim_blk_reorder_top;
  localparam int NB = 16;
  localparam int BW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          busy, done;
  logic          ld_en = 1'b0;
  logic [IW-1:0] ld_addr = '0;
  logic [BW-1:0] ld_data = '0;
  logic [IW-1:0] rd_addr = '0;
  logic [BW-1:0] rd_data;

  int n_total = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  blk_reorder_top #(.NUM_BLK(NB), .BLK_W(BW)) u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [IW-1:0] rr(input logic [IW-1:0] v);
    return {v[0], v[IW-1:1]};
  endfunction

  function automatic logic [BW-1:0] word(input int seed, input int p);
    return 32'h5A00_0000 ^ BW'(seed << 12) ^ BW'(p * 37 + 1);
  endfunction

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard: driver pushes expected words, monitor pops and compares.
  logic [BW-1:0] exp_q [$];
  string         req_q [$];
  logic          rd_req = 1'b0;
  logic          rd_req_d = 1'b0;

  always @(posedge clk) rd_req_d <= rd_req;

  always @(negedge clk) begin
    if (rd_req_d && exp_q.size() > 0) begin
      chk(req_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic rd_push(input int a, input logic [BW-1:0] e, input string req);
    @(negedge clk);
    rd_addr = IW'(a);
    rd_req  = 1'b1;
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic rd_end();
    @(negedge clk);
    rd_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load(input int seed);
    for (int p = 0; p < NB; p++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = IW'(p); ld_data = word(seed, p);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Runs once; if disturb is set, pulses start and a junk write mid-run.
  task automatic run(input bit disturb);
    int pulses = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", {31'd0, busy}, 32'd1);
    for (int c = 0; c < 200; c++) begin
      if (disturb && c == 5) begin
        start = 1'b1; ld_en = 1'b1; ld_addr = IW'(3); ld_data = 32'hDEAD_BEEF;
      end else begin
        start = 1'b0; ld_en = 1'b0;
      end
      if (done) begin
        pulses++;
        chk("R5 busy low with done", {31'd0, busy}, 32'd0);
      end
      @(negedge clk);
    end
    start = 1'b0; ld_en = 1'b0;
    chk(disturb ? "R6 single done pulse" : "R5 single done pulse", pulses, 1);
    chk("R5 idle after run", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, busy, done}, 32'd0);

    // R8: plain load and read-back while idle.
    load(3);
    for (int q = 0; q < NB; q++) rd_push(q, word(3, q), "R8 idle read");
    rd_end();

    // R2/R3: single clean run.
    load(1);
    run(1'b0);
    for (int q = 0; q < NB; q++)
      rd_push(q, word(1, int'(rr(IW'(q)))),
              (q == 0 || q == NB-1) ? "R3 fixed slot" : "R2 single run");
    rd_end();

    // R2: second run applies the permutation again.
    run(1'b0);
    for (int q = 0; q < NB; q++)
      rd_push(q, word(1, int'(rr(rr(IW'(q))))), "R2 double run");
    rd_end();

    // R6/R7: mid-run start and load write are dropped.
    load(2);
    run(1'b1);
    for (int q = 0; q < NB; q++)
      rd_push(q, word(2, int'(rr(IW'(q)))), "R6 R7 disturbed run");
    rd_end();

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule